// File: doc/BRIEF.md
# Chunked Firmware Image Receive Sequencer

This block sits on the controller side of a shared-memory mailbox. A host uses it to deliver a firmware image in pieces. The host first issues an arm command. That command clears the mailbox words, which are a 32-bit status, a controller flag and a host flag. The host then issues a start command. The sequencer stores a 2 KB header and then takes 128 KB data pieces. The pieces alternate between a low half-buffer and a high half-buffer, and their total count is set by the `N_CHUNKS` parameter.

The two sides pace each other with the two flags and with ASCII-coded status words. For a low piece, the host raises its flag and the controller answers by dropping its own flag. For a high piece, the host drops its flag and the controller answers by raising its own. Each piece causes a one-cycle storage-write request. The sequencer then waits for a write-complete input that carries a pass or fail flag. A failed write ends the transfer with the bad-storage code. After the last piece the status becomes done and the block returns to idle. Either ending raises a one-cycle result strobe.

Top module: `fwx_loader`

## Requirements
- R1: After reset, status_o is 0, ctrl_flag_o is 0, and wr_req_o and result_valid_o are 0.
- R2: A command word 0x10FE with cmd_valid_i arms the sequencer. On the next cycle status_o is 0, ctrl_flag_o is 0 and wr_index_o is 0.
- R3: A start command (0x20FE) that is not preceded by an arm command, or that arrives after a transfer has ended, produces no write request.
- R4: A start command on an armed sequencer raises wr_req_o on the next cycle with wr_kind_o = 0 (header).
- R5: A successful header write sets status_o to 0x54784C4F (send low) and ctrl_flag_o to 1.
- R6: In the send-low state, host_flag_i = 1 raises a request with wr_kind_o = 1 on the next cycle. While host_flag_i is 0 no request is made. A successful low write clears ctrl_flag_o and sets status_o to 0x54784849 (send high), unless it was the last piece.
- R7: In the send-high state, host_flag_i = 0 raises a request with wr_kind_o = 2 on the next cycle. A successful high write sets ctrl_flag_o to 1 and status_o to 0x54784C4F, unless it was the last piece.
- R8: wr_req_o is high for exactly one cycle per piece. No new request is made while a write is outstanding.
- R9: A write that completes with wr_ok_i = 0 sets status_o to 0x4241444E, pulses result_valid_o with result_ok_o = 0, and returns the sequencer to idle.
- R10: Completion of data piece N_CHUNKS sets status_o to 0x444F4E45 and pulses result_valid_o with result_ok_o = 1. wr_index_o then reads N_CHUNKS.
- R11: An arm command received mid-transfer abandons that transfer and re-arms the sequencer, with the status, flag and index all cleared.
- R12: wr_index_o equals the number of data pieces stored since the last arm command. It therefore reads k while piece k (counting from 0) is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_i | input | 16 | Command word (0x10FE arm, 0x20FE start) |
| host_flag_i | input | 1 | Host flag word, bit 0 |
| wr_done_i | input | 1 | Storage write finished |
| wr_ok_i | input | 1 | Storage write passed (qualified by wr_done_i) |
| status_o | output | 32 | Mailbox status word |
| ctrl_flag_o | output | 1 | Controller flag word, bit 0 |
| wr_req_o | output | 1 | One-cycle storage write request |
| wr_kind_o | output | 2 | Piece kind: 0 header, 1 low, 2 high |
| wr_index_o | output | $clog2(N_CHUNKS+1) | Data pieces stored since arm |
| result_valid_o | output | 1 | One-cycle end-of-transfer strobe |
| result_ok_o | output | 1 | Transfer result, valid with result_valid_o |

## Verification
The assertions assume a well-behaved environment:
- cmd_valid_i is a single-cycle strobe.
- wr_done_i is raised only after a request has been seen, and only once per request.
- wr_ok_i matters only while wr_done_i is high.

The stimulus waits to observe wr_req_o before it raises wr_done_i, and it holds wr_done_i for one cycle. It also changes the host flag only once the posted status calls for it, apart from deliberate stale-flag intervals that check that no request appears early.

// File: rtl/fwx_pkg.sv
package fwx_pkg;
  localparam int unsigned CMD_W = 16;
  localparam int unsigned ST_W  = 32;

  localparam logic [CMD_W-1:0] CMD_ARM   = 16'h10FE;
  localparam logic [CMD_W-1:0] CMD_START = 16'h20FE;

  // ASCII-coded mailbox status words
  localparam logic [ST_W-1:0] ST_CLEAR = 32'h0000_0000;
  localparam logic [ST_W-1:0] ST_DONE  = 32'h444F_4E45;
  localparam logic [ST_W-1:0] ST_BADST = 32'h4241_444E;
  localparam logic [ST_W-1:0] ST_SNDLO = 32'h5478_4C4F;
  localparam logic [ST_W-1:0] ST_SNDHI = 32'h5478_4849;

  typedef enum logic [1:0] {
    KIND_HDR = 2'd0,
    KIND_LO  = 2'd1,
    KIND_HI  = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ARMED  = 3'd1,
    PH_HDR_WR = 3'd2,
    PH_LO_WT  = 3'd3,
    PH_LO_WR  = 3'd4,
    PH_HI_WT  = 3'd5,
    PH_HI_WR  = 3'd6
  } phase_e;
endpackage

// File: rtl/fwx_cmd_decode.sv
module fwx_cmd_decode
  import fwx_pkg::*;
(
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             arm_o,
  output logic             start_o
);
  always_comb begin
    arm_o   = cmd_valid_i && (cmd_i == CMD_ARM);
    start_o = cmd_valid_i && (cmd_i == CMD_START);
  end
endmodule

// File: rtl/fwx_chunk_ctr.sv
module fwx_chunk_ctr #(
  parameter int unsigned N_CHUNKS = 4,
  localparam int unsigned CW = $clog2(N_CHUNKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i && cnt_q != CW'(N_CHUNKS)) cnt_q <= cnt_q + 1'b1;
  end

  assign idx_o  = cnt_q;
  assign last_o = (cnt_q == CW'(N_CHUNKS - 1));
endmodule

// File: rtl/fwx_seq.sv
module fwx_seq
  import fwx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            start_i,
  input  logic            host_flag_i,
  input  logic            wr_done_i,
  input  logic            wr_ok_i,
  input  logic            last_i,
  output logic [ST_W-1:0] status_o,
  output logic            ctrl_flag_o,
  output logic            wr_req_o,
  output kind_e           wr_kind_o,
  output logic            ctr_clr_o,
  output logic            ctr_inc_o,
  output logic            result_valid_o,
  output logic            result_ok_o
);
  phase_e          phase_q;
  logic [ST_W-1:0] status_q;
  logic            flag_q, req_q, rv_q, rok_q;
  kind_e           kind_q;
  logic            data_wr, data_pass;

  always_comb begin
    data_wr   = (phase_q == PH_LO_WR) || (phase_q == PH_HI_WR);
    data_pass = data_wr && wr_done_i && wr_ok_i && !arm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      status_q <= ST_CLEAR;
      flag_q   <= 1'b0;
      req_q    <= 1'b0;
      kind_q   <= KIND_HDR;
      rv_q     <= 1'b0;
      rok_q    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      rv_q  <= 1'b0;
      rok_q <= 1'b0;
      if (arm_i) begin
        phase_q  <= PH_ARMED;
        status_q <= ST_CLEAR;
        flag_q   <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_ARMED: if (start_i) begin
            phase_q <= PH_HDR_WR;
            req_q   <= 1'b1;
            kind_q  <= KIND_HDR;
          end
          PH_HDR_WR: if (wr_done_i) begin
            flag_q <= 1'b1;
            if (wr_ok_i) begin
              status_q <= ST_SNDLO;
              phase_q  <= PH_LO_WT;
            end else begin
              status_q <= ST_BADST;
              phase_q  <= PH_IDLE;
              rv_q     <= 1'b1;
            end
          end
          PH_LO_WT: if (host_flag_i) begin
            phase_q <= PH_LO_WR;
            req_q   <= 1'b1;
            kind_q  <= KIND_LO;
          end
          PH_HI_WT: if (!host_flag_i) begin
            phase_q <= PH_HI_WR;
            req_q   <= 1'b1;
            kind_q  <= KIND_HI;
          end
          PH_LO_WR, PH_HI_WR: if (wr_done_i) begin
            // answer the host by toggling, then post the outcome
            flag_q <= (phase_q == PH_HI_WR);
            if (!wr_ok_i) begin
              status_q <= ST_BADST;
              phase_q  <= PH_IDLE;
              rv_q     <= 1'b1;
            end else if (last_i) begin
              status_q <= ST_DONE;
              phase_q  <= PH_IDLE;
              rv_q     <= 1'b1;
              rok_q    <= 1'b1;
            end else if (phase_q == PH_LO_WR) begin
              status_q <= ST_SNDHI;
              phase_q  <= PH_HI_WT;
            end else begin
              status_q <= ST_SNDLO;
              phase_q  <= PH_LO_WT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign status_o       = status_q;
  assign ctrl_flag_o    = flag_q;
  assign wr_req_o       = req_q;
  assign wr_kind_o      = kind_q;
  assign ctr_clr_o      = arm_i;
  assign ctr_inc_o      = data_pass;
  assign result_valid_o = rv_q;
  assign result_ok_o    = rok_q;
endmodule

// File: rtl/fwx_loader.sv
module fwx_loader
  import fwx_pkg::*;
#(
  parameter int unsigned N_CHUNKS = 4,
  localparam int unsigned CW = $clog2(N_CHUNKS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [15:0]     cmd_i,
  input  logic            host_flag_i,
  input  logic            wr_done_i,
  input  logic            wr_ok_i,
  output logic [31:0]     status_o,
  output logic            ctrl_flag_o,
  output logic            wr_req_o,
  output logic [1:0]      wr_kind_o,
  output logic [CW-1:0]   wr_index_o,
  output logic            result_valid_o,
  output logic            result_ok_o
);
  logic  arm, start, last, ctr_clr, ctr_inc;
  kind_e kind;

  fwx_cmd_decode u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .arm_o       (arm),
    .start_o     (start)
  );

  fwx_chunk_ctr #(.N_CHUNKS(N_CHUNKS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr),
    .inc_i  (ctr_inc),
    .idx_o  (wr_index_o),
    .last_o (last)
  );

  fwx_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arm_i          (arm),
    .start_i        (start),
    .host_flag_i    (host_flag_i),
    .wr_done_i      (wr_done_i),
    .wr_ok_i        (wr_ok_i),
    .last_i         (last),
    .status_o       (status_o),
    .ctrl_flag_o    (ctrl_flag_o),
    .wr_req_o       (wr_req_o),
    .wr_kind_o      (kind),
    .ctr_clr_o      (ctr_clr),
    .ctr_inc_o      (ctr_inc),
    .result_valid_o (result_valid_o),
    .result_ok_o    (result_ok_o)
  );

  assign wr_kind_o = kind;
endmodule

// File: rtl/fwx_loader_chk.sv
module fwx_loader_chk
  import fwx_pkg::*;
#(
  parameter int unsigned N_CHUNKS = 4,
  localparam int unsigned CW = $clog2(N_CHUNKS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [15:0]   cmd_i,
  input logic          host_flag_i,
  input logic          wr_done_i,
  input logic          wr_ok_i,
  input logic [31:0]   status_o,
  input logic          ctrl_flag_o,
  input logic          wr_req_o,
  input logic [1:0]    wr_kind_o,
  input logic [CW-1:0] wr_index_o,
  input logic          result_valid_o,
  input logic          result_ok_o
);
  assert_arm_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_ARM) |=> (status_o == ST_CLEAR && !ctrl_flag_o && wr_index_o == '0));

  assert_hdr_after_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_kind_o == KIND_HDR) |-> $past(cmd_valid_i && cmd_i == CMD_START));

  assert_status_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_CLEAR || status_o == ST_SNDLO || status_o == ST_SNDHI ||
     status_o == ST_DONE  || status_o == ST_BADST));

  assert_lo_handshake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_kind_o == KIND_LO) |-> (ctrl_flag_o && $past(host_flag_i) && status_o == ST_SNDLO));

  assert_hi_handshake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_kind_o == KIND_HI) |-> (!ctrl_flag_o && !$past(host_flag_i) && status_o == ST_SNDHI));

  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o);

  assert_fail_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !result_ok_o) |-> status_o == ST_BADST);

  assert_done_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && result_ok_o) |-> (status_o == ST_DONE && wr_index_o == CW'(N_CHUNKS)));

  assert_result_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
endmodule

bind fwx_loader fwx_loader_chk #(.N_CHUNKS(N_CHUNKS)) chk_i (.*);

// File: tb/fwx_loader_tb_top.sv
module fwx_loader_tb_top;
  localparam int unsigned NC = 4;
  localparam int unsigned CW = $clog2(NC + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [15:0]   cmd = '0;
  logic          host_flag = 1'b0;
  logic          wr_done = 1'b0;
  logic          wr_ok = 1'b0;
  logic [31:0]   status_o;
  logic          ctrl_flag_o, wr_req_o, result_valid_o, result_ok_o;
  logic [1:0]    wr_kind_o;
  logic [CW-1:0] wr_index_o;

  always #4 clk = ~clk;

  fwx_loader #(.N_CHUNKS(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .host_flag_i(host_flag), .wr_done_i(wr_done), .wr_ok_i(wr_ok),
    .status_o(status_o), .ctrl_flag_o(ctrl_flag_o), .wr_req_o(wr_req_o),
    .wr_kind_o(wr_kind_o), .wr_index_o(wr_index_o),
    .result_valid_o(result_valid_o), .result_ok_o(result_ok_o)
  );

  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: mailbox phases as plain integers
  int          m_ph;   // 0 idle,1 armed,2 header,3 want low,4 low pending,5 want high,6 high pending
  logic [31:0] m_st;
  bit          m_fl, m_req, m_rv, m_rok;
  int          m_kind, m_stored;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_fl = 0; m_req = 0; m_rv = 0; m_rok = 0; m_kind = 0; m_stored = 0;
    end else begin
      m_req = 0; m_rv = 0; m_rok = 0;
      if (cmd_valid && cmd == 16'h10FE) begin
        m_ph = 1; m_st = 0; m_fl = 0; m_stored = 0;
      end else if (m_ph == 1 && cmd_valid && cmd == 16'h20FE) begin
        m_ph = 2; m_req = 1; m_kind = 0;
      end else if (m_ph == 3 && host_flag) begin
        m_ph = 4; m_req = 1; m_kind = 1;
      end else if (m_ph == 5 && !host_flag) begin
        m_ph = 6; m_req = 1; m_kind = 2;
      end else if ((m_ph == 2 || m_ph == 4 || m_ph == 6) && wr_done) begin
        m_fl = (m_ph != 4);
        if (!wr_ok) begin
          m_st = 32'h4241444E; m_ph = 0; m_rv = 1;
        end else if (m_ph == 2) begin
          m_st = 32'h54784C4F; m_ph = 3;
        end else begin
          m_stored++;
          if (m_stored == NC) begin
            m_st = 32'h444F4E45; m_ph = 0; m_rv = 1; m_rok = 1;
          end else if (m_ph == 4) begin
            m_st = 32'h54784849; m_ph = 5;
          end else begin
            m_st = 32'h54784C4F; m_ph = 3;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk({cur_tag, " model status"}, status_o, m_st);
      chk({cur_tag, " model flag"}, {31'b0, ctrl_flag_o}, {31'b0, m_fl});
      chk({cur_tag, " model req"}, {31'b0, wr_req_o}, {31'b0, m_req});
      if (m_req) chk({cur_tag, " model kind"}, {30'b0, wr_kind_o}, m_kind);
      chk({cur_tag, " model index"}, {{(32-CW){1'b0}}, wr_index_o}, m_stored);
      chk({cur_tag, " model result"}, {30'b0, result_valid_o, result_valid_o & result_ok_o},
          {30'b0, m_rv, m_rok});
    end
  end

  task automatic send(input logic [15:0] c);
    @(negedge clk); cmd_valid = 1; cmd = c;
    @(negedge clk); cmd_valid = 0; cmd = '0;
  endtask

  task automatic no_req(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " no request"}, {31'b0, wr_req_o}, 0);
    end
  endtask

  task automatic serve(input logic [1:0] kind, input bit ok, input int dly,
                       input int idx, input string tag);
    int t = 0;
    while (!wr_req_o && t < 50) begin @(negedge clk); t++; end
    chk({tag, " R8 request seen"}, {31'b0, wr_req_o}, 1);
    chk({tag, " kind"}, {30'b0, wr_kind_o}, {30'b0, kind});
    chk("R12 index at request", {{(32-CW){1'b0}}, wr_index_o}, idx);
    if (dly > 0) begin
      @(negedge clk);
      chk("R8 request one cycle", {31'b0, wr_req_o}, 0);
      for (int i = 1; i < dly; i++) @(negedge clk);
    end
    wr_done = 1; wr_ok = ok;
    @(negedge clk); wr_done = 0; wr_ok = 0;
  endtask

  // fail_at: -1 none, -2 header, k = data piece k
  task automatic run_xfer(input int fail_at, input int dly);
    host_flag = 0;
    send(16'h10FE);
    chk("R2 status after arm", status_o, 32'h0);
    send(16'h20FE);
    serve(2'd0, fail_at != -2, dly, 0, "R4");
    if (fail_at == -2) begin
      chk("R9 header fail status", status_o, 32'h4241444E);
      chk("R9 result", {30'b0, result_valid_o, result_ok_o}, 32'h2);
      return;
    end
    chk("R5 status", status_o, 32'h54784C4F);
    chk("R5 flag", {31'b0, ctrl_flag_o}, 1);
    for (int k = 0; k < NC; k++) begin
      if (dly > 0) no_req(2, (k % 2 == 0) ? "R6 stale host flag" : "R7 stale host flag");
      if (k % 2 == 0) begin
        host_flag = 1;
        serve(2'd1, k != fail_at, dly, k, "R6");
      end else begin
        host_flag = 0;
        serve(2'd2, k != fail_at, dly, k, "R7");
      end
      if (k == fail_at) begin
        chk("R9 status", status_o, 32'h4241444E);
        chk("R9 result", {30'b0, result_valid_o, result_ok_o}, 32'h2);
        return;
      end else if (k == NC - 1) begin
        chk("R10 status", status_o, 32'h444F4E45);
        chk("R10 result", {30'b0, result_valid_o, result_ok_o}, 32'h3);
        chk("R10 index", {{(32-CW){1'b0}}, wr_index_o}, NC);
      end else if (k % 2 == 0) begin
        chk("R6 status", status_o, 32'h54784849);
        chk("R6 flag", {31'b0, ctrl_flag_o}, 0);
      end else begin
        chk("R7 status", status_o, 32'h54784C4F);
        chk("R7 flag", {31'b0, ctrl_flag_o}, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1 status", status_o, 32'h0);
    chk("R1 flag/req/result", {29'b0, ctrl_flag_o, wr_req_o, result_valid_o}, 0);

    cur_tag = "R3";
    send(16'h20FE);
    no_req(4, "R3 start without arm");

    cur_tag = "R10";
    run_xfer(-1, 0);
    @(negedge clk);
    chk("R10 result one cycle", {31'b0, result_valid_o}, 0);
    cur_tag = "R8";
    run_xfer(-1, 3);

    cur_tag = "R9";
    run_xfer(1, 2);
    send(16'h20FE);
    no_req(3, "R9 start after failure");
    run_xfer(-2, 1);
    run_xfer(2, 0);

    cur_tag = "R11";
    host_flag = 0;
    send(16'h10FE);
    send(16'h20FE);
    serve(2'd0, 1, 0, 0, "R11");
    host_flag = 1;
    serve(2'd1, 1, 1, 0, "R11");
    chk("R11 mid status", status_o, 32'h54784849);
    send(16'h10FE);
    chk("R11 status cleared", status_o, 32'h0);
    chk("R11 flag cleared", {31'b0, ctrl_flag_o}, 0);
    chk("R11 index cleared", {{(32-CW){1'b0}}, wr_index_o}, 0);
    host_flag = 0;
    no_req(3, "R11 armed waits for start");
    send(16'h20FE);
    serve(2'd0, 1, 0, 0, "R11");
    run_xfer(-1, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule